// File: doc/BRIEF.md
# Up-Counting Timer with Shadow Update

This block is a general-purpose up-counting timer core. A programmable prescaler divides the input clock, and an up-counter runs from zero to an auto-reload value before it wraps back to zero. A repetition counter decides how many wraps pass before an update event is issued. Software reaches every control through a single 16-bit register port with a write strobe, a write address, a read address and a combinational read path.

The prescale ratio, the auto-reload value and the repetition value are each held twice. A write lands in a preload copy, and the working (shadow) copy takes that value only at an update event. An update event comes either from a counter wrap when the repetition count has run out, or from a software force command.

A filter control stops forced updates from setting the sticky update flag. A disable control blocks update events altogether. The interrupt output is the flag gated by an enable bit.

Top module: `upcnt_timer`

## Requirements
- R1: After reset the counter, the update flag and `irq` are 0. The prescaler and repetition preloads read 0, the auto-reload preload reads 0xFFFF, and the control register reads 0.
- R2: The prescaler divides by its shadow ratio plus 1. While control bit 0 (count enable) is 1, the counter advances once every ratio+1 clocks. While that bit is 0, neither the counter nor the prescaler moves.
- R3: The counter counts up to the auto-reload shadow value. On the next counter step it returns to 0, and that step is an overflow.
- R4: Writes to address 4 (prescaler), address 5 (auto-reload) and address 6 (repetition) change only the preload copies, which read back at those addresses. The shadow copies take the preload values on each update event.
- R5: An overflow issues an update event only when the repetition counter is 0. Otherwise the overflow decrements the repetition counter. Every update event reloads the repetition counter from its preload.
- R6: Writing 1 to bit 0 of address 2 forces an update. The counter and the prescaler's internal count restart from 0, and an update event is issued. The prescale ratio in use is not changed by the command itself. Address 2 reads 0.
- R7: When control bit 2 (request filter) is 1, a forced update still issues an update event but does not set the flag. Overflow updates still set the flag.
- R8: When control bit 1 (update disable) is 1, no update event is issued and the shadow copies keep their values. A forced update still restarts the counter and the prescaler.
- R9: The update flag (bit 0 of address 1) is set by each update event that is not filtered and stays set. Writing 0 to that bit clears the flag, and writing 1 has no effect. If a set and a clear fall in the same cycle, the set wins.
- R10: `irq` is 1 exactly when the flag is 1 and control bit 3 (interrupt enable) is 1.
- R11: A write to address 3 loads the counter with the written value. A forced update in the same cycle takes precedence over the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, which is also the prescaler input |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Read data for rd_addr, combinational |
| upd_evt | output | 1 | Update event pulse, valid in the cycle it is issued |
| irq | output | 1 | Update interrupt request |

## Verification
Register writes, counter steps, shadow loads and flag changes all take effect at the clock edge that follows the cycle in which they are requested. A read in the next cycle therefore reflects them. `upd_evt` is combinational, so it is due in the same cycle as its cause, which is either the force write or the step from the auto-reload value. `irq` follows the flag one edge after the flag-setting event. The bench drives each stimulus at the falling edge. Shortly after driving it, the bench compares `upd_evt`, `irq` and `rd_data` against a reference model that holds the state as of the previous edge, and only then advances the model by one cycle. Every result is therefore compared in the exact cycle it becomes due.

// File: rtl/upt_pkg.sv
package upt_pkg;

    localparam int unsigned ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL  = 3'd0,
        A_STAT  = 3'd1,
        A_FORCE = 3'd2,
        A_COUNT = 3'd3,
        A_PSC   = 3'd4,
        A_ARR   = 3'd5,
        A_REP   = 3'd6
    } upt_addr_e;

    typedef struct packed {
        logic irq_en;
        logic req_filter;
        logic upd_dis;
        logic cnt_en;
    } upt_ctrl_t;

    localparam int unsigned CTRL_W = $bits(upt_ctrl_t);

    function automatic upt_ctrl_t ctrl_from_word(input logic [CTRL_W-1:0] w);
        upt_ctrl_t c;
        c = upt_ctrl_t'(w);
        return c;
    endfunction

endpackage

// File: rtl/upt_prescaler.sv
module upt_prescaler #(
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cen,
    input  logic          restart,
    input  logic          load,
    input  logic [DW-1:0] psc_pre,
    output logic          tick,
    output logic [DW-1:0] pcnt
);
    logic [DW-1:0] psc_sh;

    assign tick = cen && (pcnt == psc_sh);

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt   <= '0;
            psc_sh <= '0;
        end else begin
            if (load) psc_sh <= psc_pre;
            if (restart)   pcnt <= '0;
            else if (tick) pcnt <= '0;
            else if (cen)  pcnt <= pcnt + 1'b1;
        end
    end

    // Internal count never runs past the active ratio.
    assert_pcnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
        pcnt <= psc_sh);

    // A halted prescaler holds its count unless restarted.
    assert_halt_R2: assert property (@(posedge clk) disable iff (rst)
        (!cen && !restart) |=> $stable(pcnt));

endmodule

// File: rtl/upt_counter.sv
module upt_counter #(
    parameter int unsigned DW      = 16,
    parameter logic [DW-1:0] ARR_RST = '1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          restart,
    input  logic          cnt_we,
    input  logic [DW-1:0] cnt_wdata,
    input  logic          load,
    input  logic [DW-1:0] arr_pre,
    input  logic [DW-1:0] rep_pre,
    output logic [DW-1:0] cnt,
    output logic [DW-1:0] arr_sh,
    output logic          ovf,
    output logic          rep_zero
);
    logic [DW-1:0] rep_cnt;

    assign ovf      = tick && !restart && !cnt_we && (cnt == arr_sh);
    assign rep_zero = (rep_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            arr_sh  <= ARR_RST;
            rep_cnt <= '0;
        end else begin
            if (restart)     cnt <= '0;
            else if (cnt_we) cnt <= cnt_wdata;
            else if (tick)   cnt <= (cnt == arr_sh) ? '0 : cnt + 1'b1;

            if (load) begin
                arr_sh  <= arr_pre;
                rep_cnt <= rep_pre;
            end else if (ovf && !rep_zero) begin
                rep_cnt <= rep_cnt - 1'b1;
            end
        end
    end

    assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        ovf |=> (cnt == '0));

    assert_load_R11: assert property (@(posedge clk) disable iff (rst)
        (cnt_we && !restart) |=> (cnt == $past(cnt_wdata)));

endmodule

// File: rtl/upcnt_timer.sv
module upcnt_timer
    import upt_pkg::*;
#(
    parameter int unsigned   DW      = 16,
    parameter logic [DW-1:0] ARR_RST = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DW-1:0]     rd_data,
    output logic              upd_evt,
    output logic              irq
);
    upt_ctrl_t     ctrl;
    logic          flag;
    logic [DW-1:0] psc_pre, arr_pre, rep_pre;
    logic [DW-1:0] cnt, arr_sh, pcnt;
    logic          tick, ovf, rep_zero;
    logic          force_upd, cnt_we, stat_clr, flag_set;
    upt_addr_e     waddr;

    assign waddr     = upt_addr_e'(wr_addr);
    assign force_upd = wr_en && (waddr == A_FORCE) && wr_data[0];
    assign cnt_we    = wr_en && (waddr == A_COUNT);
    assign stat_clr  = wr_en && (waddr == A_STAT) && !wr_data[0];
    assign upd_evt   = (force_upd || (ovf && rep_zero)) && !ctrl.upd_dis;
    assign flag_set  = upd_evt && !(force_upd && ctrl.req_filter);
    assign irq       = flag && ctrl.irq_en;

    upt_prescaler #(.DW(DW)) u_psc (
        .clk     (clk),
        .rst     (rst),
        .cen     (ctrl.cnt_en),
        .restart (force_upd),
        .load    (upd_evt),
        .psc_pre (psc_pre),
        .tick    (tick),
        .pcnt    (pcnt)
    );

    upt_counter #(.DW(DW), .ARR_RST(ARR_RST)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .restart   (force_upd),
        .cnt_we    (cnt_we),
        .cnt_wdata (wr_data),
        .load      (upd_evt),
        .arr_pre   (arr_pre),
        .rep_pre   (rep_pre),
        .cnt       (cnt),
        .arr_sh    (arr_sh),
        .ovf       (ovf),
        .rep_zero  (rep_zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            psc_pre <= '0;
            arr_pre <= ARR_RST;
            rep_pre <= '0;
        end else if (wr_en) begin
            case (waddr)
                A_CTRL:  ctrl    <= ctrl_from_word(wr_data[CTRL_W-1:0]);
                A_PSC:   psc_pre <= wr_data;
                A_ARR:   arr_pre <= wr_data;
                A_REP:   rep_pre <= wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           flag <= 1'b0;
        else if (flag_set) flag <= 1'b1;
        else if (stat_clr) flag <= 1'b0;
    end

    always_comb begin
        rd_data = '0;
        case (upt_addr_e'(rd_addr))
            A_CTRL:  rd_data[CTRL_W-1:0] = ctrl;
            A_STAT:  rd_data[0] = flag;
            A_COUNT: rd_data = cnt;
            A_PSC:   rd_data = psc_pre;
            A_ARR:   rd_data = arr_pre;
            A_REP:   rd_data = rep_pre;
            default: rd_data = '0;
        endcase
    end

    assert_restart_R6: assert property (@(posedge clk) disable iff (rst)
        force_upd |=> (cnt == '0 && pcnt == '0));

    assert_rep_gate_R5: assert property (@(posedge clk) disable iff (rst)
        (ovf && !rep_zero) |-> !upd_evt);

    assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (rst)
        ctrl.upd_dis |=> $stable(arr_sh));

    assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (flag && !stat_clr) |=> flag);

    assert_filter_R7: assert property (@(posedge clk) disable iff (rst)
        (force_upd && ctrl.req_filter && !flag) |=> !flag);

endmodule

// File: tb/test_upcnt_timer.sv
module test_upcnt_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        upd_evt, irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference state
    logic [15:0] m_cnt, m_pc, m_psc, m_arr, m_rep;
    logic [15:0] m_psc_p, m_arr_p, m_rep_p;
    logic [3:0]  m_ctrl;
    logic        m_flag;

    always #10 clk = ~clk;

    upcnt_timer i_upcnt_timer (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .upd_evt(upd_evt), .irq(irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_read(input logic [2:0] a);
        case (a)
            3'd0: return {12'd0, m_ctrl};
            3'd1: return {15'd0, m_flag};
            3'd3: return m_cnt;
            3'd4: return m_psc_p;
            3'd5: return m_arr_p;
            3'd6: return m_rep_p;
            default: return 16'd0;
        endcase
    endfunction

    function automatic logic exp_uev(input logic we, input logic [2:0] a, input logic [15:0] d);
        logic frc, cw, tk, of;
        frc = we && a == 3'd2 && d[0];
        cw  = we && a == 3'd3;
        tk  = m_ctrl[0] && m_pc == m_psc;
        of  = tk && !frc && !cw && m_cnt == m_arr;
        return (frc || (of && m_rep == 0)) && !m_ctrl[1];
    endfunction

    task automatic model_reset();
        m_cnt = 0; m_pc = 0; m_psc = 0; m_arr = 16'hFFFF; m_rep = 0;
        m_psc_p = 0; m_arr_p = 16'hFFFF; m_rep_p = 0; m_ctrl = 0; m_flag = 0;
    endtask

    task automatic model_step(input logic we, input logic [2:0] a, input logic [15:0] d);
        logic frc, cw, tk, of, uev, fset;
        frc  = we && a == 3'd2 && d[0];
        cw   = we && a == 3'd3;
        tk   = m_ctrl[0] && m_pc == m_psc;
        of   = tk && !frc && !cw && m_cnt == m_arr;
        uev  = exp_uev(we, a, d);
        fset = uev && !(frc && m_ctrl[2]);
        if (frc) m_cnt = 0;
        else if (cw) m_cnt = d;
        else if (tk) m_cnt = (m_cnt == m_arr) ? 16'd0 : m_cnt + 16'd1;
        if (frc || tk) m_pc = 0;
        else if (m_ctrl[0]) m_pc = m_pc + 16'd1;
        if (uev) begin
            m_rep = m_rep_p; m_arr = m_arr_p; m_psc = m_psc_p;
        end else if (of && m_rep != 0) m_rep = m_rep - 16'd1;
        if (fset) m_flag = 1'b1;
        else if (we && a == 3'd1 && !d[0]) m_flag = 1'b0;
        if (we) case (a)
            3'd0: m_ctrl = d[3:0];
            3'd4: m_psc_p = d;
            3'd5: m_arr_p = d;
            3'd6: m_rep_p = d;
            default: ;
        endcase
    endtask

    // One cycle: drive at the falling edge, compare, then advance the model.
    task automatic step(input logic we, input logic [2:0] a, input logic [15:0] d,
                        input logic [2:0] ra, input string tag);
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d; rd_addr = ra;
        #1;
        chk({tag, " read"}, rd_data, exp_read(ra));
        chk("R5 R6 update event", {15'd0, upd_evt}, {15'd0, exp_uev(we, a, d)});
        chk("R10 irq", {15'd0, irq}, {15'd0, m_flag && m_ctrl[3]});
        model_step(we, a, d);
    endtask

    task automatic idle(input int n, input logic [2:0] ra, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 3'd0, 16'd0, ra, tag);
    endtask

    initial begin
        #(20ns * 190000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1 reset values
        for (int a = 0; a < 8; a++) step(1'b0, 3'd0, 16'd0, 3'(a), "R1");
        chk("R1 irq", {15'd0, irq}, 16'd0);
        // R11 direct counter load while halted
        step(1'b1, 3'd3, 16'h0034, 3'd3, "R11");
        idle(3, 3'd3, "R11 hold R2");
        // R3: reload 0x36, force, then run from 0x34
        step(1'b1, 3'd5, 16'h0036, 3'd5, "R4");
        step(1'b1, 3'd2, 16'h0001, 3'd3, "R6");
        step(1'b1, 3'd3, 16'h0034, 3'd3, "R11");
        step(1'b1, 3'd0, 16'h0001, 3'd3, "R3");
        idle(6, 3'd3, "R3");
        // R2 divide by 2
        step(1'b1, 3'd4, 16'h0001, 3'd4, "R4");
        step(1'b1, 3'd2, 16'h0001, 3'd3, "R6");
        idle(12, 3'd3, "R2");
        // R9 write 1 keeps flag, write 0 clears
        step(1'b1, 3'd1, 16'h0001, 3'd1, "R9");
        step(1'b1, 3'd1, 16'h0000, 3'd1, "R9");
        idle(1, 3'd1, "R9");
        // R7 filtered force
        step(1'b1, 3'd0, 16'h0005, 3'd1, "R7");
        step(1'b1, 3'd2, 16'h0001, 3'd1, "R7");
        idle(2, 3'd1, "R7");
        // R10 irq enable
        step(1'b1, 3'd0, 16'h0009, 3'd1, "R10");
        step(1'b1, 3'd4, 16'h0000, 3'd1, "R10");
        step(1'b1, 3'd2, 16'h0001, 3'd1, "R10");
        idle(2, 3'd1, "R10");
        // R8 disable: new reload must not take effect
        step(1'b1, 3'd0, 16'h000B, 3'd3, "R8");
        step(1'b1, 3'd5, 16'h0003, 3'd3, "R8");
        step(1'b1, 3'd2, 16'h0001, 3'd3, "R8");
        idle(70, 3'd3, "R8");
        // R5 repetition with reload 3
        step(1'b1, 3'd0, 16'h0009, 3'd3, "R5");
        step(1'b1, 3'd6, 16'h0002, 3'd6, "R5");
        step(1'b1, 3'd2, 16'h0001, 3'd3, "R5");
        idle(30, 3'd3, "R5");
        // constrained random traffic
        void'($urandom(32'd2024));
        for (int n = 0; n < 6000; n++) begin
            logic we; logic [2:0] a, ra; logic [15:0] d;
            we = ($urandom % 4) == 0;
            a  = 3'($urandom % 8);
            d  = 16'($urandom);
            if (a == 3'd2 && ($urandom % 3) != 0) d[0] = 1'b0;
            if (a == 3'd4) d = d % 4;
            if (a == 3'd5 || a == 3'd3) d = d % 24;
            if (a == 3'd6) d = d % 3;
            if (a == 3'd0 && ($urandom % 2) == 0) d[1] = 1'b0;
            if (a == 3'd0) d[0] = 1'b1;
            ra = 3'($urandom % 8);
            step(we, a, d, ra, "R4 R2 R3 R9 random");
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule